// File: doc/BRIEF.md
# ADC Conversion Timing Controller

This block sequences the digital side of a successive-approximation converter. A programmable divider turns the system clock into a conversion clock enable. Every phase length is counted in ticks of that enable. When a conversion is requested, the block first powers the analog core and waits a startup interval chosen by a 4-bit code, but only if the core is powered down at that point. It then walks through three timed phases: tracking, settling and transfer. A one-cycle end-of-conversion pulse marks the finish.

A request comes from one of three places: a software strobe, the rising edge of a hardware trigger, or a continuous free-run enable. A trigger-select input chooses between the strobe and the hardware trigger. Three power policies are available:
- Normal: the core stays powered after its first warm-up.
- Sleep: the core and the reference both power down between conversions.
- Sleep with fast wake-up: only the core powers down, and the reference stays on.

A request that arrives while a conversion is running is held and serviced immediately after it. A synchronous software reset abandons all activity.

Top module: `adc_conv_timer`

## Requirements
- R1: `conv_tick_o` pulses for one cycle every 2×(P+1) clock cycles, where P is `prescale_i`. The divider restarts when a conversion is launched from idle, so a phase of N ticks lasts exactly N×2×(P+1) cycles.
- R2: The startup wait in ticks for codes 0 to 15 is:
  - codes 0 to 3: code×8;
  - codes 4 to 7: 64+(code−4)×16;
  - codes 8 to 15: 512+(code−8)×64.
  
  A code of 0 skips the startup phase and goes straight to tracking.
- R3: Tracking lasts `track_i` ticks. A value of 0 counts as 1 tick.
- R4: Settling lasts `settle_i`+1 ticks and always follows tracking.
- R5: Transfer lasts 2×`xfer_i`+3 ticks.
- R6: `eoc_o` is high for exactly one cycle, the cycle right after the last transfer cycle. At most one phase indicator is high at any time.
- R7: With `sleep_i` low, the first conversion after reset runs startup. After that the core stays powered, and later conversions start tracking one cycle after the request, with no startup.
- R8: With `sleep_i` high and `fast_wake_i` low, `core_pwr_o` and `ref_pwr_o` are both low between conversions. Every conversion runs the full startup wait.
- R9: While `fast_wake_i` is high, `ref_pwr_o` stays high. In sleep mode the core still powers down between conversions and startup still runs.
- R10: When `trig_sel_hw_i` is 1, `sw_start_i` has no effect and a rising edge of `hw_trig_i` starts a conversion. When it is 0, `hw_trig_i` has no effect.
- R11: With `free_run_i` high and `sleep_i` low, conversions run back to back with no idle cycle between them. With `sleep_i` high, `free_run_i` is ignored.
- R12: A request received while a conversion is busy is held. The next tracking phase then begins in the same cycle as `eoc_o`. Without a held request the block goes idle.
- R13: A `soft_rst_i` pulse stops any conversion. In the next cycle all phase indicators and `core_pwr_o` are low, no `eoc_o` follows, and the next conversion runs startup again.
- R14: After `rst_ni` is released, all phase indicators, `eoc_o`, `core_pwr_o` and `ref_pwr_o` are low, provided `fast_wake_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset command |
| prescale_i | input | 8 | Divider setting P |
| startup_code_i | input | 4 | Encoded startup wait |
| track_i | input | 4 | Tracking length in ticks |
| settle_i | input | 2 | Settling length minus one |
| xfer_i | input | 2 | Transfer length code |
| sleep_i | input | 1 | Power down between conversions |
| fast_wake_i | input | 1 | Keep reference powered |
| trig_sel_hw_i | input | 1 | 1: hardware trigger source, 0: software strobe |
| sw_start_i | input | 1 | Software start strobe |
| hw_trig_i | input | 1 | Hardware trigger, rising edge active |
| free_run_i | input | 1 | Continuous conversion enable |
| conv_tick_o | output | 1 | Conversion clock enable |
| startup_o | output | 1 | Startup phase active |
| track_o | output | 1 | Tracking phase active |
| settle_o | output | 1 | Settling phase active |
| xfer_o | output | 1 | Transfer phase active |
| core_pwr_o | output | 1 | Analog core power enable |
| ref_pwr_o | output | 1 | Reference power enable |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The hardest case to reach is a request that is held during a busy conversion. It has to land while a phase is running, and the bench must then see that tracking restarts in the exact cycle of the end-of-conversion pulse. The bench gets there by issuing a second software strobe a few cycles into tracking, with a known short phase setting. It then samples the tracking indicator in the pulse cycle, and repeats the run without the second strobe for contrast. The same cycle-exact counting gives the back-to-back interval in free-run mode. It also covers the long non-linear startup codes, which the bench measures in sleep mode so that every conversion has to pay the startup wait.

// File: rtl/adc_tmr_pkg.sv
package adc_tmr_pkg;
  localparam int CNT_W = 10;

  typedef enum logic [2:0] {
    ST_DOWN, ST_READY, ST_WARM, ST_TRACK, ST_SETTLE, ST_XFER
  } phase_e;

  // non-linear startup map: three linear segments
  function automatic logic [CNT_W-1:0] startup_ticks(input logic [3:0] code);
    if (code[3])      return {1'b1, code[2:0], 6'd0};
    else if (code[2]) return CNT_W'(64) + {4'd0, code[1:0], 4'd0};
    else              return {5'd0, code[1:0], 3'd0};
  endfunction
endpackage

// File: rtl/adc_tmr_div.sv
module adc_tmr_div #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PRESC_W-1:0] prescale_i,
  output logic               tick_o
);
  localparam int DIV_W = PRESC_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit  = {prescale_i, 1'b1};
  assign tick_o = (div_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (clr_i || tick_o)  div_q <= '0;
    else                       div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/adc_tmr_req.sv
module adc_tmr_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic trig_sel_hw_i,
  input  logic sw_start_i,
  input  logic hw_trig_i,
  input  logic free_run_i,
  input  logic sleep_i,
  output logic req_o
);
  logic hw_prev_q;
  logic hw_edge;
  logic one_shot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hw_prev_q <= 1'b0;
    else if (soft_rst_i) hw_prev_q <= 1'b0;
    else                 hw_prev_q <= hw_trig_i;
  end

  assign hw_edge  = hw_trig_i & ~hw_prev_q;
  assign one_shot = trig_sel_hw_i ? hw_edge : sw_start_i;
  // free-run is barred in sleep mode
  assign req_o    = one_shot | (free_run_i & ~sleep_i);
endmodule

// File: rtl/adc_tmr_fsm.sv
module adc_tmr_fsm
  import adc_tmr_pkg::*;
#(
  parameter int TRACK_W  = 4,
  parameter int SETTLE_W = 2,
  parameter int XFER_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                tick_i,
  input  logic                req_i,
  input  logic                sleep_i,
  input  logic [3:0]          startup_code_i,
  input  logic [TRACK_W-1:0]  track_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [XFER_W-1:0]   xfer_i,
  output phase_e              state_o,
  output logic                launch_o,
  output logic                eoc_o
);
  phase_e           state_q, state_d;
  logic [CNT_W-1:0] ph_q, ph_d, len, su_len;
  logic             pend_q, pend_d, eoc_d, last;

  always_comb begin
    su_len = startup_ticks(startup_code_i);
    case (state_q)
      ST_WARM:   len = su_len;
      ST_TRACK:  len = (track_i == '0) ? CNT_W'(1) : CNT_W'(track_i);
      ST_SETTLE: len = CNT_W'(settle_i) + CNT_W'(1);
      ST_XFER:   len = CNT_W'({xfer_i, 1'b1}) + CNT_W'(2);
      default:   len = CNT_W'(1);
    endcase
    last = tick_i && (ph_q >= len - CNT_W'(1));
  end

  always_comb begin
    state_d  = state_q;
    ph_d     = ph_q;
    pend_d   = pend_q;
    eoc_d    = 1'b0;
    launch_o = 1'b0;
    case (state_q)
      ST_DOWN, ST_READY: begin
        if (req_i) begin
          launch_o = 1'b1;
          ph_d     = '0;
          pend_d   = 1'b0;
          state_d  = (state_q == ST_DOWN && su_len != '0) ? ST_WARM : ST_TRACK;
        end else if (state_q == ST_READY && sleep_i) begin
          state_d = ST_DOWN;
        end
      end
      default: begin
        if (req_i)  pend_d = 1'b1;
        if (tick_i) ph_d = ph_q + CNT_W'(1);
        if (last) begin
          ph_d = '0;
          case (state_q)
            ST_WARM:   state_d = ST_TRACK;
            ST_TRACK:  state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_XFER;
            default: begin
              eoc_d   = 1'b1;
              pend_d  = 1'b0;
              if (pend_q || req_i) state_d = ST_TRACK;
              else                 state_d = sleep_i ? ST_DOWN : ST_READY;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DOWN;
      ph_q    <= '0;
      pend_q  <= 1'b0;
      eoc_o   <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_DOWN;
      ph_q    <= '0;
      pend_q  <= 1'b0;
      eoc_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      pend_q  <= pend_d;
      eoc_o   <= eoc_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_tmr_pkg::*;
#(
  parameter int PRESC_W  = 8,
  parameter int TRACK_W  = 4,
  parameter int SETTLE_W = 2,
  parameter int XFER_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [PRESC_W-1:0]  prescale_i,
  input  logic [3:0]          startup_code_i,
  input  logic [TRACK_W-1:0]  track_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [XFER_W-1:0]   xfer_i,
  input  logic                sleep_i,
  input  logic                fast_wake_i,
  input  logic                trig_sel_hw_i,
  input  logic                sw_start_i,
  input  logic                hw_trig_i,
  input  logic                free_run_i,
  output logic                conv_tick_o,
  output logic                startup_o,
  output logic                track_o,
  output logic                settle_o,
  output logic                xfer_o,
  output logic                core_pwr_o,
  output logic                ref_pwr_o,
  output logic                eoc_o
);
  phase_e state;
  logic   tick, req, launch;

  adc_tmr_div #(.PRESC_W(PRESC_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (launch | soft_rst_i),
    .prescale_i (prescale_i),
    .tick_o     (tick)
  );

  adc_tmr_req u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .trig_sel_hw_i (trig_sel_hw_i),
    .sw_start_i    (sw_start_i),
    .hw_trig_i     (hw_trig_i),
    .free_run_i    (free_run_i),
    .sleep_i       (sleep_i),
    .req_o         (req)
  );

  adc_tmr_fsm #(
    .TRACK_W  (TRACK_W),
    .SETTLE_W (SETTLE_W),
    .XFER_W   (XFER_W)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .soft_rst_i     (soft_rst_i),
    .tick_i         (tick),
    .req_i          (req),
    .sleep_i        (sleep_i),
    .startup_code_i (startup_code_i),
    .track_i        (track_i),
    .settle_i       (settle_i),
    .xfer_i         (xfer_i),
    .state_o        (state),
    .launch_o       (launch),
    .eoc_o          (eoc_o)
  );

  assign conv_tick_o = tick;
  assign startup_o   = (state == ST_WARM);
  assign track_o     = (state == ST_TRACK);
  assign settle_o    = (state == ST_SETTLE);
  assign xfer_o      = (state == ST_XFER);
  assign core_pwr_o  = (state != ST_DOWN);
  assign ref_pwr_o   = core_pwr_o | fast_wake_i;
endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic sleep_i,
  input logic fast_wake_i,
  input logic startup_o,
  input logic track_o,
  input logic settle_o,
  input logic xfer_o,
  input logic core_pwr_o,
  input logic ref_pwr_o,
  input logic eoc_o
);
  assert_one_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({startup_o, track_o, settle_o, xfer_o}));

  assert_eoc_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  assert_eoc_after_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> $past(xfer_o));

  assert_settle_follows_track_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settle_o) |-> $past(track_o));

  assert_stay_powered_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !sleep_i && !soft_rst_i) |=> core_pwr_o);

  assert_sleep_ref_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !fast_wake_i && !core_pwr_o) |-> !ref_pwr_o);

  assert_fast_ref_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_wake_i |-> ref_pwr_o);

  assert_soft_reset_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!core_pwr_o && !track_o && !eoc_o));
endmodule

bind adc_conv_timer adc_conv_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .sleep_i     (sleep_i),
  .fast_wake_i (fast_wake_i),
  .startup_o   (startup_o),
  .track_o     (track_o),
  .settle_o    (settle_o),
  .xfer_o      (xfer_o),
  .core_pwr_o  (core_pwr_o),
  .ref_pwr_o   (ref_pwr_o),
  .eoc_o       (eoc_o)
);

// File: tb/sim_adc_conv_timer.sv
module sim_adc_conv_timer;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [7:0] prescale = 8'd0;
  logic [3:0] code = 4'd1;
  logic [3:0] track = 4'd2;
  logic [1:0] settle = 2'd1;
  logic [1:0] xfer = 2'd0;
  logic       sleep = 1'b0, fast = 1'b0, tsel = 1'b0;
  logic       sw = 1'b0, hw = 1'b0, frun = 1'b0;
  logic       tick, su_o, tr_o, st_o, xf_o, core, refp, eoc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_conv_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .prescale_i(prescale),
    .startup_code_i(code), .track_i(track), .settle_i(settle), .xfer_i(xfer),
    .sleep_i(sleep), .fast_wake_i(fast), .trig_sel_hw_i(tsel), .sw_start_i(sw),
    .hw_trig_i(hw), .free_run_i(frun), .conv_tick_o(tick), .startup_o(su_o),
    .track_o(tr_o), .settle_o(st_o), .xfer_o(xf_o), .core_pwr_o(core),
    .ref_pwr_o(refp), .eoc_o(eoc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sw();
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
  endtask

  // counts phase cycles from the current negedge until eoc
  task automatic measure(output int su, output int tr, output int st,
                         output int xf, output int ew);
    su = 0; tr = 0; st = 0; xf = 0; ew = 0;
    for (int i = 0; i < 5000; i++) begin
      if (eoc) begin
        ew = 1;
        @(negedge clk);
        if (eoc) ew++;
        return;
      end
      su += int'(su_o); tr += int'(tr_o); st += int'(st_o); xf += int'(xf_o);
      @(negedge clk);
    end
  endtask

  task automatic wait_eoc(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!eoc && n < 5000);
  endtask

  task automatic quiet(input int n, output int busy);
    busy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (su_o || tr_o || eoc) busy++;
    end
  endtask

  task automatic t_reset();
    chk(!su_o && !tr_o && !st_o && !xf_o, "R14 phases", int'({su_o,tr_o,st_o,xf_o}), 0);
    chk(!core && !refp, "R14 power", int'({core,refp}), 0);
    chk(!eoc, "R14 eoc", int'(eoc), 0);
  endtask

  task automatic t_normal();
    int su, tr, st, xf, ew;
    pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 16, "R2 startup code1", su, 16);
    chk(tr == 4, "R3 track", tr, 4);
    chk(st == 4, "R4 settle", st, 4);
    chk(xf == 6, "R5 xfer0", xf, 6);
    chk(ew == 1, "R6 eoc width", ew, 1);
    chk(core == 1'b1, "R7 stays powered", int'(core), 1);
    track = 4'd0; xfer = 2'd1;
    pulse_sw();
    chk(tr_o == 1'b1, "R7 no startup", int'(tr_o), 1);
    measure(su, tr, st, xf, ew);
    chk(su == 0, "R7 startup skipped", su, 0);
    chk(tr == 2, "R3 track zero as one", tr, 2);
    chk(xf == 10, "R5 xfer1", xf, 10);
    track = 4'd2; xfer = 2'd0;
  endtask

  task automatic t_presc();
    int n, su, tr, st, xf, ew;
    prescale = 8'd3;
    @(negedge clk);
    n = 0;
    while (!tick && n < 100) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    chk(n == 8, "R1 tick period", n, 8);
    pulse_sw(); measure(su, tr, st, xf, ew);
    chk(tr == 16 && st == 16 && xf == 24, "R1 phase scaling", tr + st + xf, 56);
    prescale = 8'd0;
  endtask

  task automatic t_sleep();
    int su, tr, st, xf, ew;
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    chk(!core && !refp, "R8 idle power off", int'({core,refp}), 0);
    code = 4'd2; pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 32, "R8 startup every conv", su, 32);
    chk(!core && !refp, "R8 off after conv", int'({core,refp}), 0);
    code = 4'd4; pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 128, "R2 code4", su, 128);
    code = 4'd9; pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 1152, "R2 code9", su, 1152);
    code = 4'd15; pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 1920, "R2 code15", su, 1920);
    code = 4'd0; pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 0 && tr == 4, "R2 code0 skip", su, 0);
    code = 4'd1;
  endtask

  task automatic t_fast();
    int su, tr, st, xf, ew;
    fast = 1'b1;
    @(negedge clk);
    chk(!core && refp, "R9 idle ref on", int'({core,refp}), 1);
    pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 16, "R9 startup runs", su, 16);
    chk(!core && refp, "R9 core off ref on", int'({core,refp}), 1);
    fast = 1'b0;
  endtask

  task automatic t_trig();
    int busy, su, tr, st, xf, ew;
    tsel = 1'b1;
    pulse_sw(); quiet(20, busy);
    chk(busy == 0 && !core, "R10 sw ignored", busy, 0);
    hw = 1'b1;
    @(negedge clk);
    measure(su, tr, st, xf, ew);
    chk(su == 16 && ew == 1, "R10 hw edge starts", su, 16);
    hw = 1'b0;
    @(negedge clk);
    tsel = 1'b0;
    hw = 1'b1; quiet(20, busy); hw = 1'b0;
    chk(busy == 0, "R10 hw ignored", busy, 0);
  endtask

  task automatic t_freerun();
    int busy, n;
    frun = 1'b1;
    quiet(40, busy);
    chk(busy == 0 && !core, "R11 ignored in sleep", busy, 0);
    sleep = 1'b0;
    wait_eoc(n);
    wait_eoc(n);
    chk(n == 14, "R11 back to back", n, 14);
    frun = 1'b0;
    repeat (60) @(negedge clk);
    quiet(30, busy);
    chk(busy == 0, "R11 stops", busy, 0);
  endtask

  task automatic t_pend();
    int n;
    pulse_sw();
    repeat (2) @(negedge clk);
    pulse_sw();
    wait_eoc(n);
    chk(tr_o == 1'b1, "R12 pending served", int'(tr_o), 1);
    wait_eoc(n);
    chk(tr_o == 1'b0 && core, "R12 idle after", int'(tr_o), 0);
  endtask

  task automatic t_swrst();
    int busy, su, tr, st, xf, ew;
    pulse_sw();
    repeat (3) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(!su_o && !tr_o && !st_o && !xf_o && !core, "R13 stopped",
        int'({su_o,tr_o,st_o,xf_o,core}), 0);
    quiet(30, busy);
    chk(busy == 0, "R13 no eoc", busy, 0);
    pulse_sw(); measure(su, tr, st, xf, ew);
    chk(su == 16, "R13 startup again", su, 16);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_presc();
    t_sleep();
    t_fast();
    t_trig();
    t_freerun();
    t_pend();
    t_swrst();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule